// File: doc/BRIEF.md
# Shared-Pin Boundary Scan Controller

This block puts a standard four-wire test access port and a simpler serial programming port behind one set of four pins. A level on a separate select pin decides who owns them. With the select high, the pins feed a 16-state test controller, a 4-bit instruction register, a one-bit bypass register and a boundary chain that covers a parameterised number of bidirectional pads and input-only pads. With the select low, the clock, mode and data pins are passed straight to an external programming engine, whose serial output is returned on the shared data-out pin. Every user pad is released to high impedance.

The block sits between the core logic and the pad ring. In normal operation, and under the BYPASS and SAMPLE instructions, core values pass to the pads untouched. Under EXTEST the pads are driven from the boundary update latches instead.

Top module: `scan_port_mux`

## Requirements
- R1: While `sel_pin` is high, `prg_clk`, `prg_mode` and `prg_din` are held at 0 whatever the shared pins do.
- R2: While `sel_pin` is low, `prg_clk` follows `sclk_pin`, `prg_mode` follows `mode_pin` and `prg_din` follows `din_pin`. `dout_pin` carries `prg_dout`, with `dout_oe` at 1.
- R3: While `sel_pin` is low, every bit of `pad_oe` is 0, even if EXTEST latches request drive. The controller is held in its reset state, so on return to test mode the active instruction is BYPASS.
- R4: `tap_rst_n` low resets the controller asynchronously, with no clock edge needed. Pads return to core control, `dout_oe` drops, and the update latches clear to 0.
- R5: Five consecutive rising clock edges with `mode_pin` high bring the controller to its reset state from any state. At that point the pads are under core control.
- R6: The instruction register is 4 bits wide, shifts least significant bit first and loads 0001 in its capture state.
- R7: Code 1111, and any code other than 0000 and 0010, selects the one-bit bypass register. This register loads 0 on capture, so data-out lags data-in by one bit.
- R8: Code 0010 (SAMPLE) loads the boundary chain on capture without disturbing the pads. Bit 3i of the chain holds `pad_in[i]`, bit 3i+1 holds `core_out[i]` and bit 3i+2 holds `core_oe[i]`. Bit 3·NUM_BIDIR+j holds `in_pad[j]`. Bit 0 leaves first.
- R9: Code 0000 (EXTEST) drives `pad_out[i]` from the update latch of chain bit 3i+1 and `pad_oe[i]` from that of bit 3i+2. Changes on `core_out` and `core_oe` have no effect. The latches load from the chain in Update-DR.
- R10: Data-in is sampled on the rising clock edge and data-out changes on the falling edge. In test mode `dout_oe` is 1 only while in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_pin | input | 1 | Shared serial clock pin |
| tap_rst_n | input | 1 | Asynchronous active-low controller reset |
| sel_pin | input | 1 | Owner select: 1 test port, 0 programming port |
| mode_pin | input | 1 | Shared mode/state-select pin |
| din_pin | input | 1 | Shared serial data-in pin |
| dout_pin | output | 1 | Shared serial data-out pin |
| dout_oe | output | 1 | Drive enable for dout_pin |
| prg_clk | output | 1 | Clock to programming engine |
| prg_mode | output | 1 | Mode to programming engine |
| prg_din | output | 1 | Serial data to programming engine |
| prg_dout | input | 1 | Serial data from programming engine |
| core_out | input | NUM_BIDIR | Core output values for bidirectional pads |
| core_oe | input | NUM_BIDIR | Core output enables for bidirectional pads |
| pad_in | input | NUM_BIDIR | Values seen on bidirectional pads |
| in_pad | input | NUM_INPUT | Values seen on input-only pads |
| pad_out | output | NUM_BIDIR | Value driven to each bidirectional pad |
| pad_oe | output | NUM_BIDIR | Drive enable for each bidirectional pad |

## Verification
The bench aims at the exits from EXTEST. It changes the core values and walks four edges with mode high, then a fifth, so that a controller that resets too early or too late shows the wrong pad source. It also pulls the asynchronous reset between edges, and a design that resets synchronously would leave the pads on the latches. It enters programming mode with latches that request drive, so a design that gates only the core enables keeps a pad driven. An undecoded instruction code must act as bypass, and a bit-order mistake in the chain shows up in the fourteen captured bits.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;

    localparam int IR_W = 4;
    localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 4'b0001;
    localparam logic [IR_W-1:0] OP_EXTEST      = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE      = 4'b0010;
    localparam logic [IR_W-1:0] OP_BYPASS      = 4'b1111;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {DR_BYPASS, DR_SAMPLE, DR_EXTEST} dr_path_e;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        case (s)
            ST_RESET:    return m ? ST_RESET    : ST_IDLE;
            ST_IDLE:     return m ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   return m ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   return m ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: return m ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: return m ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: return m ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: return m ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   return m ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   return m ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   return m ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: return m ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: return m ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: return m ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: return m ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   return m ? ST_SEL_DR   : ST_IDLE;
            default:     return ST_RESET;
        endcase
    endfunction

    function automatic dr_path_e decode_op(logic [IR_W-1:0] op);
        case (op)
            OP_EXTEST: return DR_EXTEST;
            OP_SAMPLE: return DR_SAMPLE;
            default:   return DR_BYPASS;
        endcase
    endfunction

    function automatic logic in_shift(tap_state_e s);
        return (s == ST_SHIFT_DR) || (s == ST_SHIFT_IR);
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       park,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)    state <= ST_RESET;
        else if (park) state <= ST_RESET;
        else           state <= tap_next(state, tms);
    end

    // checker: consecutive mode-high edges seen so far
    logic [2:0] ones_cnt;
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)             ones_cnt <= '0;
        else if (!tms)          ones_cnt <= '0;
        else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
    end

    assert_reset_walk_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (tms && ones_cnt >= 3'd4) |=> (state == ST_RESET));

    assert_park_hold_R3: assert property (@(posedge tck) disable iff (!rst_n)
        park |=> (state == ST_RESET));

endmodule

// File: rtl/scan_instr.sv
`timescale 1ns/1ps
module scan_instr
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       park,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       ir_lsb,
    output dr_path_e   path
);

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            ir_sr <= IR_CAPTURE_VAL;
            ir_q  <= OP_BYPASS;
        end else begin
            if (park || state == ST_RESET) ir_q <= OP_BYPASS;
            else if (state == ST_UPD_IR)   ir_q <= ir_sr;
            if (state == ST_CAP_IR)        ir_sr <= IR_CAPTURE_VAL;
            else if (state == ST_SHIFT_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    assign ir_lsb = ir_sr[0];
    assign path   = (state == ST_RESET) ? DR_BYPASS : decode_op(ir_q);

    assert_ir_capture_R6: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE_VAL));

endmodule

// File: rtl/scan_boundary.sv
`timescale 1ns/1ps
module scan_boundary
    import scan_pkg::*;
#(
    parameter int NUM_BIDIR = 4,
    parameter int NUM_INPUT = 2
) (
    input  logic                 tck,
    input  logic                 rst_n,
    input  tap_state_e           state,
    input  dr_path_e             path,
    input  logic                 tdi,
    input  logic [NUM_BIDIR-1:0] pad_in,
    input  logic [NUM_BIDIR-1:0] core_out,
    input  logic [NUM_BIDIR-1:0] core_oe,
    input  logic [NUM_INPUT-1:0] in_pad,
    output logic                 chain_lsb,
    output logic [NUM_BIDIR-1:0] upd_out,
    output logic [NUM_BIDIR-1:0] upd_oe
);

    localparam int CHAIN_LEN = 3 * NUM_BIDIR + NUM_INPUT;

    logic [CHAIN_LEN-1:0] cap_vec;
    logic [CHAIN_LEN-1:0] chain_q;

    for (genvar i = 0; i < NUM_BIDIR; i++) begin : g_bidir
        assign cap_vec[3*i]   = pad_in[i];
        assign cap_vec[3*i+1] = core_out[i];
        assign cap_vec[3*i+2] = core_oe[i];
    end
    for (genvar j = 0; j < NUM_INPUT; j++) begin : g_inonly
        assign cap_vec[3*NUM_BIDIR+j] = in_pad[j];
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (path != DR_BYPASS) begin
            if (state == ST_CAP_DR)        chain_q <= cap_vec;
            else if (state == ST_SHIFT_DR) chain_q <= {tdi, chain_q[CHAIN_LEN-1:1]};
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            upd_out <= '0;
            upd_oe  <= '0;
        end else if (state == ST_UPD_DR && path != DR_BYPASS) begin
            for (int i = 0; i < NUM_BIDIR; i++) begin
                upd_out[i] <= chain_q[3*i+1];
                upd_oe[i]  <= chain_q[3*i+2];
            end
        end
    end

    assign chain_lsb = chain_q[0];

    for (genvar i = 0; i < NUM_BIDIR; i++) begin : g_chk
        assert_latch_load_R9: assert property (@(posedge tck) disable iff (!rst_n)
            (state == ST_UPD_DR && path != DR_BYPASS) |=>
            (upd_out[i] == $past(chain_q[3*i+1]) && upd_oe[i] == $past(chain_q[3*i+2])));
    end

endmodule

// File: rtl/scan_port_mux.sv
`timescale 1ns/1ps
module scan_port_mux
    import scan_pkg::*;
#(
    parameter int NUM_BIDIR = 4,
    parameter int NUM_INPUT = 2
) (
    input  logic                 sclk_pin,
    input  logic                 tap_rst_n,
    input  logic                 sel_pin,
    input  logic                 mode_pin,
    input  logic                 din_pin,
    output logic                 dout_pin,
    output logic                 dout_oe,
    output logic                 prg_clk,
    output logic                 prg_mode,
    output logic                 prg_din,
    input  logic                 prg_dout,
    input  logic [NUM_BIDIR-1:0] core_out,
    input  logic [NUM_BIDIR-1:0] core_oe,
    input  logic [NUM_BIDIR-1:0] pad_in,
    input  logic [NUM_INPUT-1:0] in_pad,
    output logic [NUM_BIDIR-1:0] pad_out,
    output logic [NUM_BIDIR-1:0] pad_oe
);

    logic       park;
    logic       tms_t;
    tap_state_e tap_st;
    dr_path_e   path;
    logic       ir_lsb;
    logic       chain_lsb;
    logic       byp_q;
    logic       tdo_next;
    logic       tdo_q;
    logic       tdo_oe_q;
    logic [NUM_BIDIR-1:0] upd_out;
    logic [NUM_BIDIR-1:0] upd_oe;

    // pin steering
    assign park     = !sel_pin;
    assign tms_t    = sel_pin ? mode_pin : 1'b1;
    assign prg_clk  = park & sclk_pin;
    assign prg_mode = park & mode_pin;
    assign prg_din  = park & din_pin;

    scan_tap_fsm u_fsm (
        .tck   (sclk_pin),
        .rst_n (tap_rst_n),
        .park  (park),
        .tms   (tms_t),
        .state (tap_st)
    );

    scan_instr u_ir (
        .tck    (sclk_pin),
        .rst_n  (tap_rst_n),
        .park   (park),
        .state  (tap_st),
        .tdi    (din_pin),
        .ir_lsb (ir_lsb),
        .path   (path)
    );

    scan_boundary #(
        .NUM_BIDIR (NUM_BIDIR),
        .NUM_INPUT (NUM_INPUT)
    ) u_bsr (
        .tck       (sclk_pin),
        .rst_n     (tap_rst_n),
        .state     (tap_st),
        .path      (path),
        .tdi       (din_pin),
        .pad_in    (pad_in),
        .core_out  (core_out),
        .core_oe   (core_oe),
        .in_pad    (in_pad),
        .chain_lsb (chain_lsb),
        .upd_out   (upd_out),
        .upd_oe    (upd_oe)
    );

    always_ff @(posedge sclk_pin or negedge tap_rst_n) begin
        if (!tap_rst_n)                 byp_q <= 1'b0;
        else if (tap_st == ST_CAP_DR)   byp_q <= 1'b0;
        else if (tap_st == ST_SHIFT_DR) byp_q <= din_pin;
    end

    always_comb begin
        if (tap_st == ST_SHIFT_IR)   tdo_next = ir_lsb;
        else if (path == DR_BYPASS)  tdo_next = byp_q;
        else                         tdo_next = chain_lsb;
    end

    always_ff @(negedge sclk_pin or negedge tap_rst_n) begin
        if (!tap_rst_n) begin
            tdo_q    <= 1'b0;
            tdo_oe_q <= 1'b0;
        end else begin
            tdo_q    <= tdo_next;
            tdo_oe_q <= in_shift(tap_st);
        end
    end

    assign dout_pin = sel_pin ? tdo_q    : prg_dout;
    assign dout_oe  = sel_pin ? tdo_oe_q : 1'b1;

    for (genvar i = 0; i < NUM_BIDIR; i++) begin : g_pad
        assign pad_out[i] = (path == DR_EXTEST) ? upd_out[i] : core_out[i];
        assign pad_oe[i]  = sel_pin & ((path == DR_EXTEST) ? upd_oe[i] : core_oe[i]);
    end

    assert_tdo_quiet_R10: assert property (@(posedge sclk_pin) disable iff (!tap_rst_n)
        !in_shift(tap_st) |-> !tdo_oe_q);

    assert_bypass_zero_R7: assert property (@(posedge sclk_pin) disable iff (!tap_rst_n)
        (tap_st == ST_CAP_DR) |=> !byp_q);

endmodule

// File: tb/tb_scan_port_mux.sv
`timescale 1ns/1ps
module tb_scan_port_mux;
    import scan_pkg::*;

    localparam int NB = 4;
    localparam int NI = 2;
    localparam int CL = 3 * NB + NI;
    localparam logic [NB-1:0] LAT_OUT = 4'b0101;
    localparam logic [NB-1:0] LAT_OE  = 4'b1100;

    logic sclk_pin = 1'b0;
    logic tap_rst_n, sel_pin, mode_pin, din_pin, prg_dout;
    logic dout_pin, dout_oe, prg_clk, prg_mode, prg_din;
    logic [NB-1:0] core_out, core_oe, pad_in, pad_out, pad_oe;
    logic [NI-1:0] in_pad;

    int total = 0;
    int fails = 0;
    bit    exp_v[$];
    string exp_t[$];

    always #2.5 sclk_pin = ~sclk_pin;

    scan_port_mux #(.NUM_BIDIR(NB), .NUM_INPUT(NI)) dut (
        .sclk_pin (sclk_pin), .tap_rst_n (tap_rst_n), .sel_pin (sel_pin),
        .mode_pin (mode_pin), .din_pin (din_pin), .dout_pin (dout_pin),
        .dout_oe (dout_oe), .prg_clk (prg_clk), .prg_mode (prg_mode),
        .prg_din (prg_din), .prg_dout (prg_dout), .core_out (core_out),
        .core_oe (core_oe), .pad_in (pad_in), .in_pad (in_pad),
        .pad_out (pad_out), .pad_oe (pad_oe)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compares serial output bits against the scoreboard queue
    always @(negedge sclk_pin) begin
        #2;
        if (sel_pin && dout_oe && exp_v.size() > 0) begin
            bit    e;
            string t;
            e = exp_v.pop_front();
            t = exp_t.pop_front();
            total++;
            if (dout_pin !== e) begin
                fails++;
                $display("FAIL %s: serial out actual %0b expected %0b", t, dout_pin, e);
            end
        end
    end

    task automatic step(input logic tms, input logic tdi);
        @(negedge sclk_pin);
        #1;
        mode_pin = tms;
        din_pin  = tdi;
    endtask

    task automatic ir_scan(input logic [3:0] code, input string tag);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int k = 0; k < 4; k++) begin
            exp_v.push_back(k == 0);
            exp_t.push_back(tag);
        end
        for (int k = 0; k < 4; k++) step(k == 3, code[k]);
        step(1, 0); step(0, 0);
        @(posedge sclk_pin); #1;
    endtask

    task automatic dr_scan(input logic [15:0] vin, input logic [15:0] vexp,
                           input int n, input string tag);
        step(1, 0); step(0, 0); step(0, 0);
        for (int k = 0; k < n; k++) begin
            exp_v.push_back(vexp[k]);
            exp_t.push_back(tag);
        end
        for (int k = 0; k < n; k++) step(k == n - 1, vin[k]);
        step(1, 0); step(0, 0);
        @(posedge sclk_pin); #1;
    endtask

    function automatic logic [15:0] cap_expect();
        logic [15:0] v = '0;
        for (int i = 0; i < NB; i++) begin
            v[3*i]   = pad_in[i];
            v[3*i+1] = core_out[i];
            v[3*i+2] = core_oe[i];
        end
        for (int j = 0; j < NI; j++) v[3*NB+j] = in_pad[j];
        return v;
    endfunction

    function automatic logic [15:0] preload_vec();
        logic [15:0] v = '0;
        for (int i = 0; i < NB; i++) begin
            v[3*i+1] = LAT_OUT[i];
            v[3*i+2] = LAT_OE[i];
        end
        return v;
    endfunction

    task automatic preload_extest();
        ir_scan(OP_SAMPLE, "R6");
        dr_scan(preload_vec(), cap_expect(), CL, "R8");
        ir_scan(OP_EXTEST, "R6");
    endtask

    initial begin
        repeat (100000) @(posedge sclk_pin);
        total++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        tap_rst_n = 1'b0; sel_pin = 1'b1; mode_pin = 1'b1; din_pin = 1'b1;
        prg_dout = 1'b0; core_out = 4'b1001; core_oe = 4'b0110;
        pad_in = 4'b0011; in_pad = 2'b10;
        #11;
        chk("R4 reset dout_oe", dout_oe, 0);
        chk("R4 reset pad_out", pad_out, core_out);
        chk("R4 reset pad_oe", pad_oe, core_oe);
        @(posedge sclk_pin); #1;
        chk("R1 prg_clk held", prg_clk, 0);
        chk("R1 prg_mode held", prg_mode, 0);
        chk("R1 prg_din held", prg_din, 0);
        @(negedge sclk_pin); #1 tap_rst_n = 1'b1;

        for (int k = 0; k < 5; k++) step(1, 0);
        step(0, 0);
        @(posedge sclk_pin); #1;
        chk("R10 idle dout_oe", dout_oe, 0);

        // bypass by explicit code, then by an undecoded code
        ir_scan(OP_BYPASS, "R6");
        dr_scan(16'b10110010, {16'b10110010 << 1}, 8, "R7");
        ir_scan(4'b0101, "R6");
        dr_scan(16'b01101001, {16'b01101001 << 1}, 8, "R7");

        // SAMPLE capture and preload, then EXTEST
        ir_scan(OP_SAMPLE, "R6");
        dr_scan(preload_vec(), cap_expect(), CL, "R8");
        chk("R8 sample pad_out", pad_out, core_out);
        chk("R8 sample pad_oe", pad_oe, core_oe);
        chk("R10 idle dout_oe after scan", dout_oe, 0);
        ir_scan(OP_EXTEST, "R6");
        chk("R9 extest pad_out", pad_out, LAT_OUT);
        chk("R9 extest pad_oe", pad_oe, LAT_OE);
        core_out = 4'b0011; core_oe = 4'b1111;
        #1;
        chk("R9 core ignored out", pad_out, LAT_OUT);
        chk("R9 core ignored oe", pad_oe, LAT_OE);

        // R5: four mode-high edges from Shift-IR keep EXTEST, the fifth resets
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        exp_v.push_back(1'b1); exp_t.push_back("R6");
        for (int k = 0; k < 4; k++) step(1, 0);
        @(posedge sclk_pin); #1;
        chk("R5 four edges pad_out", pad_out, LAT_OUT);
        step(1, 0);
        @(posedge sclk_pin); #1;
        chk("R5 fifth edge pad_out", pad_out, core_out);
        chk("R5 fifth edge pad_oe", pad_oe, core_oe);
        step(0, 0);
        @(posedge sclk_pin); #1;

        // R4: asynchronous reset between edges
        ir_scan(OP_EXTEST, "R6");
        chk("R4 pre pad_out", pad_out, LAT_OUT);
        @(negedge sclk_pin); #1;
        tap_rst_n = 1'b0;
        #0.5;
        chk("R4 async pad_out", pad_out, core_out);
        chk("R4 async pad_oe", pad_oe, core_oe);
        @(negedge sclk_pin); #1 tap_rst_n = 1'b1;
        step(0, 0);
        @(posedge sclk_pin); #1;
        ir_scan(OP_EXTEST, "R6");
        chk("R4 latch cleared out", pad_out, 0);
        chk("R4 latch cleared oe", pad_oe, 0);

        // programming mode
        preload_extest();
        chk("R9 reload pad_oe", pad_oe, LAT_OE);
        @(negedge sclk_pin); #1;
        sel_pin = 1'b0; mode_pin = 1'b1; din_pin = 1'b0; prg_dout = 1'b1;
        #0.5;
        chk("R3 hiz pad_oe", pad_oe, 0);
        @(posedge sclk_pin); #1;
        chk("R2 prg_clk high", prg_clk, 1);
        chk("R2 prg_mode", prg_mode, 1);
        chk("R2 prg_din", prg_din, 0);
        chk("R2 dout from prg", dout_pin, 1);
        chk("R2 dout_oe", dout_oe, 1);
        @(negedge sclk_pin); #1;
        mode_pin = 1'b0; din_pin = 1'b1; prg_dout = 1'b0;
        #0.5;
        chk("R2 prg_clk low", prg_clk, 0);
        chk("R2 prg_mode low", prg_mode, 0);
        chk("R2 prg_din high", prg_din, 1);
        chk("R2 dout low", dout_pin, 0);
        repeat (3) @(posedge sclk_pin);
        #1;
        chk("R3 hiz held", pad_oe, 0);
        @(negedge sclk_pin); #1;
        sel_pin = 1'b1; mode_pin = 1'b0; din_pin = 1'b0;
        #0.5;
        chk("R3 return pad_out", pad_out, core_out);
        chk("R3 return pad_oe", pad_oe, core_oe);
        @(posedge sclk_pin); #1;
        dr_scan(16'b11010011, {16'b11010011 << 1}, 8, "R3");

        repeat (4) @(posedge sclk_pin);
        finish_run();
    end

endmodule